// File: doc/BRIEF.md
# Serial Audio Frame Controller

This block runs the master side of a two-channel serial audio link. A parameter divides the system clock down to a bit clock. The block also drives a word-select line, which is low for the left channel and high for the right channel. Each channel occupies 16 bit periods, so a frame is 32 bit periods long. Transmit words arrive through a valid/ready handshake and are shifted out MSB first. Received bits are sampled on the rising bit-clock edge and are offered as 16-bit words through a second valid/ready handshake.

The controller leaves reset in a configuration state, where no transfer takes place. Raising the transmit or the receive enable moves it to the enabled state and clears the idle flag. When both enables drop, the frame in flight still runs to its end. The controller goes to the disabled state, with the idle flag raised, only after the right-channel LSB has left. A continue bit keeps the bit clock and word-select running while no transfer takes place. Two further inputs choose the idle line value: either constant zero or a padding bit.

Top module: `asp_frame_ctrl`

## Requirements
- R1: After reset the bit clock, word-select, serial output, transmit ready, receive valid and underflow are 0, and idle is 1.
- R2: While running, the bit clock toggles every HALF_DIV system clocks (one bit period is 2*HALF_DIV clocks). While stopped, the bit clock and word-select are held low.
- R3: Word-select changes only on a falling bit-clock edge. Counting bit positions 0..31 from frame start, it is high for positions 15 to 30 and low otherwise, so it leads each channel's MSB by one bit.
- R4: Transmit words are taken at slot starts (position 0 for left, position 16 for right) and shifted out MSB first, with left before right.
- R5: If an active transmit slot starts with no valid word, that channel sends 16 zeros and the underflow flag goes to 1 and stays at 1 until reset.
- R6: Received bits are sampled on the rising bit-clock edge and assembled MSB first. Each finished 16-bit word raises receive valid, which stays high with the same data until accepted by receive ready.
- R7: One clock after transmit enable or receive enable is seen at 1, idle is 0.
- R8: Once both enables are 0, idle stays 0 until the falling edge that ends position 31 of the current frame. That frame's remaining words are still sent and received, and idle rises at that edge.
- R9: With the continue bit at 1, the bit clock and word-select keep running while idle. With it at 0, both stop low at the end of the frame once no enable is set.
- R10: When no transfer frame is running, the serial output is 0 if the mute-select input is 0, and equals the padding bit if mute-select is 1.
- R11: An enable raised while word-select runs idle takes effect at the next frame start. Until then no transmit word is taken and the serial output keeps its idle value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| ws_cont | input | 1 | Keep bit clock and word-select running while idle |
| mute_sel | input | 1 | Idle output select: 0 gives zero, 1 gives the padding bit |
| pad_bit | input | 1 | Padding value driven while idle when mute_sel is 1 |
| tx_data | input | 16 | Transmit word |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Transmit word accepted this cycle |
| rx_data | output | 16 | Received word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Received word accepted |
| sd_in | input | 1 | Serial data in |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word-select, low for left and high for right |
| sd_out | output | 1 | Serial data out |
| idle | output | 1 | High when not in the enabled state |
| underflow | output | 1 | Sticky transmit underflow flag |

## Verification
Some rules are checked by assertions on every cycle. Those rules are: the bit-clock half period, both lines low while stopped, word-select moving only on a falling bit-clock edge, transmit ready appearing only at bit boundaries, underflow staying set, receive valid holding until accepted, idle clearing one cycle after an enable, and idle rising only at the end of position 31. The bench scenarios must show the rest. That covers the exact word-select pattern across a frame, MSB-first order with left before right, and zero fill on underflow. It also covers the frame in flight finishing its words after the enables drop, continue mode against stop mode, both idle output choices, and a mid-frame enable waiting for the next frame start.

// File: rtl/asp_pkg.sv
`timescale 1ns/1ps
package asp_pkg;
    localparam int WORD_W  = 16;
    localparam int FRAME_W = 2 * WORD_W;
    localparam int POS_W   = $clog2(FRAME_W);
    localparam int SLOT_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        ST_CFG = 2'd0,
        ST_ON  = 2'd1,
        ST_OFF = 2'd2
    } asp_state_e;

    typedef struct packed {
        asp_state_e       st;
        logic             run;
        logic [POS_W-1:0] pos;
        logic             ws;
        logic             act;
        logic             txa;
        logic             rxa;
        logic             uflow;
    } asp_ctl_s;
endpackage

// File: rtl/asp_sck_gen.sv
`timescale 1ns/1ps
module asp_sck_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sck_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int HC_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_DIV - 1);

    typedef struct packed {
        logic [HC_W-1:0] hc;
        logic            sck;
    } div_s;

    div_s div_d, div_q;
    logic wrap;

    always_comb begin
        div_d = div_q;
        wrap  = run_i && (div_q.hc == HC_LAST);
        if (!run_i) begin
            div_d = '0;
        end else if (wrap) begin
            div_d.hc  = '0;
            div_d.sck = ~div_q.sck;
        end else begin
            div_d.hc = div_q.hc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign sck_o  = div_q.sck;
    assign rise_o = wrap && !div_q.sck;
    assign fall_o = wrap && div_q.sck;

    // R2: every bit-clock level lasts a full half period
    p_half_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q.sck != $past(div_q.sck)) |-> ($past(div_q.hc) == HC_LAST));
endmodule

// File: rtl/asp_tx_shift.sv
`timescale 1ns/1ps
module asp_tx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    input  logic         shift_i,
    output logic         msb_o
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i)       sh_d = word_i;
        else if (shift_i) sh_d = {sh_q[W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign msb_o = sh_q[W-1];
endmodule

// File: rtl/asp_rx_shift.sv
`timescale 1ns/1ps
module asp_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample_i,
    input  logic         bit_i,
    input  logic         last_i,
    input  logic         ready_i,
    output logic         valid_o,
    output logic [W-1:0] data_o
);
    typedef struct packed {
        logic [W-1:0] sh;
        logic [W-1:0] data;
        logic         valid;
    } rx_s;

    rx_s rx_d, rx_q;

    always_comb begin
        rx_d = rx_q;
        if (rx_q.valid && ready_i) rx_d.valid = 1'b0;
        if (sample_i) begin
            rx_d.sh = {rx_q.sh[W-2:0], bit_i};
            if (last_i) begin
                rx_d.data  = {rx_q.sh[W-2:0], bit_i};
                rx_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign valid_o = rx_q.valid;
    assign data_o  = rx_q.data;

    // R6: a received word waits for its consumer
    p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.valid && !ready_i) |=> rx_q.valid);
endmodule

// File: rtl/asp_frame_ctrl.sv
`timescale 1ns/1ps
module asp_frame_ctrl
    import asp_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              ws_cont,
    input  logic              mute_sel,
    input  logic              pad_bit,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic              sd_in,
    output logic              sck,
    output logic              ws,
    output logic              sd_out,
    output logic              idle,
    output logic              underflow
);
    localparam logic [POS_W-1:0] WS_HI_FIRST = POS_W'(WORD_W - 1);
    localparam logic [POS_W-1:0] WS_HI_LAST  = POS_W'(FRAME_W - 2);
    localparam logic [POS_W-1:0] RIGHT_START = POS_W'(WORD_W);
    localparam logic [POS_W-1:0] FRAME_LAST  = POS_W'(FRAME_W - 1);

    asp_ctl_s         c_d, c_q;
    logic [POS_W-1:0] pos_n;
    logic             en_any, keep;
    logic             sck_w, rise_w, fall_w;
    logic             slot_start, tx_take, tx_shift, tx_msb;
    logic [WORD_W-1:0] tx_word;
    logic             rx_sample, rx_last;

    asp_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (c_q.run),
        .sck_o (sck_w),
        .rise_o(rise_w),
        .fall_o(fall_w)
    );

    assign en_any = tx_en | rx_en;
    assign keep   = en_any | ws_cont;
    assign pos_n  = c_q.pos + 1'b1;

    always_comb begin
        c_d        = c_q;
        slot_start = 1'b0;
        tx_shift   = 1'b0;
        if (!c_q.run) begin
            if (keep) begin
                c_d.run    = 1'b1;
                c_d.pos    = '0;
                c_d.ws     = 1'b0;
                c_d.act    = en_any;
                c_d.txa    = tx_en;
                c_d.rxa    = rx_en;
                slot_start = 1'b1;
            end
        end else if (fall_w) begin
            c_d.pos  = pos_n;
            c_d.ws   = (pos_n >= WS_HI_FIRST) && (pos_n <= WS_HI_LAST);
            tx_shift = 1'b1;
            if (pos_n == '0) begin
                c_d.act = en_any;
                c_d.txa = tx_en;
                c_d.rxa = rx_en;
                if (!keep) begin
                    c_d.run = 1'b0;
                    c_d.ws  = 1'b0;
                end else begin
                    slot_start = 1'b1;
                end
            end else if (pos_n == RIGHT_START) begin
                slot_start = 1'b1;
            end
        end

        if (en_any)
            c_d.st = ST_ON;
        else if (c_q.st == ST_ON && c_q.run && fall_w && pos_n == '0)
            c_d.st = ST_OFF;

        tx_take = slot_start && c_d.txa;
        tx_word = (tx_take && tx_valid) ? tx_data : '0;
        if (tx_take && !tx_valid) c_d.uflow = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            c_q <= '{st: ST_CFG, run: 1'b0, pos: '0, ws: 1'b0,
                     act: 1'b0, txa: 1'b0, rxa: 1'b0, uflow: 1'b0};
        else
            c_q <= c_d;
    end

    asp_tx_shift #(.W(WORD_W)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (slot_start),
        .word_i (tx_word),
        .shift_i(tx_shift),
        .msb_o  (tx_msb)
    );

    assign rx_sample = c_q.run && rise_w && c_q.rxa;
    assign rx_last   = (c_q.pos[SLOT_W-1:0] == '1);

    asp_rx_shift #(.W(WORD_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample_i(rx_sample),
        .bit_i   (sd_in),
        .last_i  (rx_last),
        .ready_i (rx_ready),
        .valid_o (rx_valid),
        .data_o  (rx_data)
    );

    assign sck       = sck_w;
    assign ws        = c_q.ws;
    assign sd_out    = c_q.act ? tx_msb : (mute_sel & pad_bit);
    assign idle      = (c_q.st != ST_ON);
    assign underflow = c_q.uflow;
    assign tx_ready  = tx_take;

    // R2: a stopped port holds both timing lines low
    p_stopped_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.run |-> (!sck_w && !c_q.ws));

    // R3: word-select moves together with a falling bit clock
    p_ws_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(c_q.ws) |-> $fell(sck_w));

    // R4: words are accepted only at bit boundaries
    p_ready_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (fall_w || !c_q.run));

    // R5: underflow never clears by itself
    p_underflow_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.uflow |=> c_q.uflow);

    // R7: any enable leaves the idle state on the next cycle
    p_enable_clears_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en || rx_en) |=> !idle);

    // R8: idle is raised only where a frame ends
    p_idle_at_frame_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle) |-> $past(fall_w && c_q.pos == FRAME_LAST));
endmodule

// File: tb/asp_frame_ctrl_test.sv
`timescale 1ns/1ps
module asp_frame_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0, rx_en = 1'b0, ws_cont = 1'b0;
    logic        mute_sel = 1'b0, pad_bit = 1'b0;
    logic [15:0] tx_data = 16'hA5C3;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [15:0] rx_data;
    logic        rx_valid;
    logic        rx_ready = 1'b1;
    logic        sd_in;
    logic        sck, ws, sd_out, idle, underflow;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [15:0] exp_q[$];
    logic [15:0] mon_exp;
    int   widx = 0;
    logic acc_pend = 1'b0;
    logic [15:0] words [0:7] = '{16'hA5C3, 16'h1234, 16'h8001, 16'h7FFE,
                                 16'h0F0F, 16'hC0DE, 16'h5A5A, 16'hFFFF};

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    asp_frame_ctrl #(.HALF_DIV(2)) uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
        .ws_cont(ws_cont), .mute_sel(mute_sel), .pad_bit(pad_bit),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .sd_in(sd_in), .sck(sck), .ws(ws), .sd_out(sd_out),
        .idle(idle), .underflow(underflow)
    );

    assign sd_in = sd_out;  // loopback

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // driver: every accepted word becomes an expected received word
    always begin
        @(negedge clk);
        if (acc_pend) begin
            widx++;
            tx_data  = words[widx % 8];
            acc_pend = 1'b0;
        end
        #2;
        if (rst_n && tx_valid && tx_ready) begin
            exp_q.push_back(tx_data);
            acc_pend = 1'b1;
        end
    end

    // monitor: compares each handed-over word with the scoreboard
    always begin
        @(negedge clk);
        #2;
        if (rst_n && rx_valid && rx_ready) begin
            mon_exp = (exp_q.size() > 0) ? exp_q.pop_front() : 16'h0000;
            chk("R6 received word", {16'h0, rx_data}, {16'h0, mon_exp});
        end
    end

    task automatic wait_rise();
        logic prev;
        prev = sck;
        forever begin
            @(negedge clk);
            if (sck && !prev) break;
            prev = sck;
        end
    endtask

    task automatic count_activity(input int n, output int rises, output int ws_hi);
        logic prev;
        prev  = sck;
        rises = 0;
        ws_hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sck && !prev) rises++;
            if (ws) ws_hi++;
            prev = sck;
        end
    endtask

    task automatic wait_ws_rise();
        logic prev;
        prev = ws;
        forever begin
            @(negedge clk);
            if (ws && !prev) break;
            prev = ws;
        end
    endtask

    task automatic wait_idle();
        while (!idle) @(negedge clk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int rises, wshi, t0, t1, ws_bad, bad, q0;
        logic [15:0] left_w, right_w, held;

        repeat (4) @(negedge clk);
        chk("R1 reset sck/ws", {30'h0, sck, ws}, 0);
        chk("R1 reset idle", {31'h0, idle}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset sck/ws/sd_out", {29'h0, sck, ws, sd_out}, 0);
        chk("R1 after reset flags", {28'h0, tx_ready, rx_valid, underflow, idle}, 1);

        // configuration state, continue bit clear: port stays quiet
        count_activity(40, rises, wshi);
        chk("R9 stopped in configuration", rises + wshi, 0);
        mute_sel = 1'b1; pad_bit = 1'b1;
        @(negedge clk);
        chk("R10 padding bit on idle line", {31'h0, sd_out}, 1);
        mute_sel = 1'b0;
        @(negedge clk);
        chk("R10 zero on idle line", {31'h0, sd_out}, 0);
        pad_bit = 1'b0;

        // phase A: normal transfer from a stopped port
        tx_valid = 1'b1;
        tx_en = 1'b1; rx_en = 1'b1;
        @(negedge clk);
        chk("R7 idle cleared after enable", {31'h0, idle}, 0);
        ws_bad = 0; t0 = 0; t1 = 0;
        for (int p = 0; p < 32; p++) begin
            wait_rise();
            if (p == 0) t0 = cyc;
            if (p == 1) t1 = cyc;
            if (ws !== ((p >= 15 && p <= 30) ? 1'b1 : 1'b0)) ws_bad++;
            if (p < 16) left_w[15-p]  = sd_out;
            else        right_w[31-p] = sd_out;
        end
        chk("R2 bit period in clocks", t1 - t0, 4);
        chk("R3 word-select pattern mismatches", ws_bad, 0);
        chk("R4 left word MSB first", {16'h0, left_w}, {16'h0, words[0]});
        chk("R4 right word MSB first", {16'h0, right_w}, {16'h0, words[1]});

        // R6: held word while consumer stalls
        rx_ready = 1'b0;
        while (!rx_valid) @(negedge clk);
        held = rx_data;
        repeat (3) @(negedge clk);
        chk("R6 valid held while stalled", {31'h0, rx_valid}, 1);
        chk("R6 data held while stalled", {16'h0, rx_data}, {16'h0, held});
        rx_ready = 1'b1;

        // R8: drop enables in the right channel, frame must finish
        wait_ws_rise();
        tx_en = 1'b0; rx_en = 1'b0;
        @(negedge clk);
        chk("R8 idle still low mid-frame", {31'h0, idle}, 0);
        wait_idle();
        chk("R8 frame ended when idle rose", {30'h0, sck, ws}, 0);
        repeat (2) @(negedge clk);
        chk("R8 in-flight words all received", exp_q.size(), 0);
        count_activity(100, rises, wshi);
        chk("R9 port stopped without continue", rises + wshi, 0);
        chk("R10 idle line zero", {31'h0, sd_out}, 0);

        // phase B: underflow
        tx_valid = 1'b0;
        tx_en = 1'b1; rx_en = 1'b1;
        repeat (6) @(negedge clk);
        chk("R5 underflow raised", {31'h0, underflow}, 1);
        while (!rx_valid) @(negedge clk);
        chk("R5 zero-filled channel", {16'h0, rx_data}, 0);
        tx_en = 1'b0; rx_en = 1'b0;
        wait_idle();
        repeat (4) @(negedge clk);
        chk("R5 underflow sticky", {31'h0, underflow}, 1);

        // phase C: continue mode
        tx_valid = 1'b1;
        ws_cont = 1'b1; mute_sel = 1'b1; pad_bit = 1'b1;
        count_activity(40, rises, wshi);
        chk("R9 clock runs while idle", {31'h0, rises > 0}, 1);
        chk("R9 still idle", {31'h0, idle}, 1);
        chk("R10 padding bit while running idle", {31'h0, sd_out}, 1);
        pad_bit = 1'b0;
        @(negedge clk);
        chk("R10 padding bit follows input", {31'h0, sd_out}, 0);
        pad_bit = 1'b1;

        wait_ws_rise();
        q0 = exp_q.size();
        tx_en = 1'b1; rx_en = 1'b1;
        @(negedge clk);
        chk("R7 idle cleared mid-frame", {31'h0, idle}, 0);
        bad = 0;
        while (ws) begin
            if (sd_out !== 1'b1) bad++;
            @(negedge clk);
        end
        chk("R11 idle value kept until frame start", bad, 0);
        chk("R11 no word taken before frame start", exp_q.size(), q0);
        repeat (200) @(negedge clk);
        tx_en = 1'b0; rx_en = 1'b0;
        wait_idle();
        count_activity(40, rises, wshi);
        chk("R9 clock keeps running after drain", {31'h0, rises > 0}, 1);
        chk("R10 padding after drain", {31'h0, sd_out}, 1);
        chk("R8 all words of phase C received", exp_q.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule